// File: doc/BRIEF.md
# AES-128 Rolled Round Encryptor with Staged Round

This block encrypts one 128-bit block under AES-128. A single round datapath is reused for all ten rounds. Each round is cut into four steps, each closed by its own full-width register: byte substitution through a constant table, cyclic row rotation, column mixing and round-key XOR. A phase register walks the state through the four steps, and a round counter repeats the sequence ten times. One block is in flight at a time. A block therefore takes 40 clock cycles from acceptance to result.

Key expansion is left to the surrounding logic. The block shows which round key it wants on `rnd_idx`, and the key source returns that key on `rnd_key` within the same cycle. The plaintext enters over a valid/ready handshake. `in_ready` stays low for the whole time a block is in flight. This is the only back-pressure: the sender holds `in_valid` and `in_block` until it sees `in_ready` high. The result has no ready signal. It sits on `out_block` from the `done` pulse until the next block is accepted, so the consumer must capture it within that window.

Top module: `aes128_staged_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `in_ready` is 1, `done` is 0, `rnd_idx` is 0 and `out_block` is all zeros.
- R2: A block is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle `in_ready` is 0 until the cycle in which `done` is 1.
- R3: `in_valid` is ignored while `in_ready` is 0. An ignored offer starts nothing and does not change the result of the block in flight.
- R4: `rnd_idx` is 0 while idle, and the initial whitening key is taken from `rnd_key` in the acceptance cycle. During round k (1 to 10) `rnd_idx` holds k for all four steps, and the key is used in the fourth step.
- R5: Byte ordering is column-major. Byte 0 is `in_block[127:120]` and is row 0 of column 0. Byte 1 is row 1 of column 0. Byte 4 is row 0 of column 1. The same mapping applies to `rnd_key` and `out_block`.
- R6: `done` is high for exactly one cycle, 40 clock edges after the acceptance edge.
- R7: The result is AES-128 encryption. Substitution is a 256-entry constant table. Row r is rotated left by r bytes. Each column is multiplied by {03}x^3+{01}x^2+{01}x+{02} modulo x^4+1 over GF(2^8), with reduction polynomial x^8+x^4+x^3+x+1. The round key is XORed bytewise. The tenth round skips column mixing. Plaintext 00112233445566778899aabbccddeeff under key 000102030405060708090a0b0c0d0e0f gives 69c4e0d86a7b0430d8cdb78070b4c55a.
- R8: `out_block` holds the last result, unchanged, from the `done` cycle until the next acceptance. A new block may be accepted in the `done` cycle itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Plaintext offered |
| in_ready | output | 1 | Core idle, offer will be taken |
| in_block | input | 128 | Plaintext block, byte 0 in bits 127:120 |
| rnd_idx | output | 4 | Round key number requested (0 to 10) |
| rnd_key | input | 128 | Round key for `rnd_idx`, valid in the same cycle |
| out_block | output | 128 | Ciphertext, held until next acceptance |
| done | output | 1 | One-cycle pulse when `out_block` is new |

## Verification
The hardest case to reach from the ports is an acceptance in the same cycle as `done`. Here the finished result has to be visible for exactly one cycle before the state register is overwritten with the next whitened plaintext. The bench reaches this case by keeping `in_valid` high with the next block for the whole time the previous one is in flight. Those early offers also cover the rule that offers made while busy are ignored. They are followed by a block with new random plaintext and key. The key source in the bench answers `rnd_idx` combinationally from its own schedule, so a key fetched in the wrong step or round shows up as a wrong ciphertext.

// File: rtl/aes128_pkg.sv
package aes128_pkg;
  localparam int BLK_W   = 128;
  localparam int NBYTES  = BLK_W / 8;
  localparam int NCOLS   = 4;
  localparam int NROWS   = NBYTES / NCOLS;
  localparam int NROUNDS = 10;
  localparam int RND_W   = $clog2(NROUNDS + 1);

  typedef enum logic [1:0] {PH_SUB, PH_SHF, PH_MIX, PH_ARK} phase_e;

  function automatic logic [7:0] xtime(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  // Builds the forward substitution table once at elaboration: p walks
  // the multiplicative group by powers of 3, q tracks its inverse.
  function automatic logic [255:0][7:0] gen_sbox();
    logic [255:0][7:0] t;
    logic [7:0] p, q;
    t = '0;
    p = 8'h01;
    q = 8'h01;
    for (int i = 0; i < 255; i++) begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      t[p] = q ^ {q[6:0], q[7]} ^ {q[5:0], q[7:6]} ^ {q[4:0], q[7:5]}
               ^ {q[3:0], q[7:4]} ^ 8'h63;
    end
    t[0] = 8'h63;
    return t;
  endfunction
endpackage

// File: rtl/aes128_sub_bytes.sv
module aes128_sub_bytes
  import aes128_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  output logic [BLK_W-1:0] st_o
);
  localparam logic [255:0][7:0] SBOX = gen_sbox();

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam int HI = BLK_W - 1 - 8 * b;
    assign st_o[HI -: 8] = SBOX[st_i[HI -: 8]];
  end
endmodule

// File: rtl/aes128_shift_rows.sv
module aes128_shift_rows
  import aes128_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  output logic [BLK_W-1:0] st_o
);
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    for (genvar r = 0; r < NROWS; r++) begin : g_row
      localparam int DST = c * NROWS + r;
      localparam int SRC = ((c + r) % NCOLS) * NROWS + r;
      assign st_o[BLK_W-1-8*DST -: 8] = st_i[BLK_W-1-8*SRC -: 8];
    end
  end
endmodule

// File: rtl/aes128_mix_columns.sv
module aes128_mix_columns
  import aes128_pkg::*;
(
  input  logic [BLK_W-1:0] st_i,
  output logic [BLK_W-1:0] st_o
);
  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    localparam int HI = BLK_W - 1 - 32 * c;
    logic [7:0] a0, a1, a2, a3;
    assign {a0, a1, a2, a3} = st_i[HI -: 32];
    assign st_o[HI -: 32] = {
      xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3,
      a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3,
      a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3,
      xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3)
    };
  end
endmodule

// File: rtl/aes128_staged_enc.sv
module aes128_staged_enc
  import aes128_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [BLK_W-1:0] in_block,
  output logic [RND_W-1:0] rnd_idx,
  input  logic [BLK_W-1:0] rnd_key,
  output logic [BLK_W-1:0] out_block,
  output logic             done
);
  logic             busy_q, done_q;
  phase_e           phase_q;
  logic [RND_W-1:0] round_q;
  logic [BLK_W-1:0] state_q, sub_q, shf_q, mix_q;
  logic [BLK_W-1:0] sub_w, shf_w, mix_w;
  logic             accept, last_rnd;

  assign accept   = in_valid && !busy_q;
  assign last_rnd = (round_q == RND_W'(NROUNDS));

  aes128_sub_bytes   u_sub (.st_i(state_q), .st_o(sub_w));
  aes128_shift_rows  u_shf (.st_i(sub_q),   .st_o(shf_w));
  aes128_mix_columns u_mix (.st_i(shf_q),   .st_o(mix_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      phase_q <= PH_SUB;
      round_q <= '0;
      state_q <= '0;
      sub_q   <= '0;
      shf_q   <= '0;
      mix_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        state_q <= in_block ^ rnd_key;
        busy_q  <= 1'b1;
        round_q <= RND_W'(1);
        phase_q <= PH_SUB;
      end else if (busy_q) begin
        unique case (phase_q)
          PH_SUB: begin
            sub_q   <= sub_w;
            phase_q <= PH_SHF;
          end
          PH_SHF: begin
            shf_q   <= shf_w;
            phase_q <= PH_MIX;
          end
          PH_MIX: begin
            mix_q   <= last_rnd ? shf_q : mix_w;
            phase_q <= PH_ARK;
          end
          PH_ARK: begin
            state_q <= mix_q ^ rnd_key;
            phase_q <= PH_SUB;
            if (last_rnd) begin
              busy_q  <= 1'b0;
              done_q  <= 1'b1;
              round_q <= '0;
            end else begin
              round_q <= round_q + 1'b1;
            end
          end
          default: phase_q <= PH_SUB;
        endcase
      end
    end
  end

  assign in_ready  = !busy_q;
  assign rnd_idx   = round_q;
  assign out_block = state_q;
  assign done      = done_q;

  // R6: the pulse follows the last key step of round ten
  assert_done_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rnd_idx) == RND_W'(NROUNDS));
  // R6: single-cycle pulse
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2: acceptance makes the input side busy
  assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R4: idle core asks for the whitening key
  assert_idle_key0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> rnd_idx == '0);
  // R4: round number only moves in the key step
  assert_round_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && phase_q != PH_ARK) |=> $stable(rnd_idx));
  // R8: result held while idle and nothing is accepted
  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> $stable(out_block));
endmodule

// File: tb/aes128_staged_enc_bench.sv
module aes128_staged_enc_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_block = '0;
  logic [3:0]   rnd_idx;
  logic [127:0] rnd_key;
  logic [127:0] out_block;
  logic         done;

  int checks = 0;
  int errors = 0;

  logic [7:0]          sb [256];
  logic [10:0][127:0]  sched = '0;

  // reference model state
  bit           m_busy = 1'b0;
  bit           m_done = 1'b0;
  int           m_k = 0;
  logic [127:0] m_exp = '0;
  logic [127:0] m_held = '0;

  always #2 clk = ~clk;

  aes128_staged_enc u_aes128_staged_enc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_block(in_block), .rnd_idx(rnd_idx), .rnd_key(rnd_key),
    .out_block(out_block), .done(done)
  );

  always_comb rnd_key = (rnd_idx <= 4'd10) ? sched[rnd_idx] : '0;

  function automatic logic [7:0] gm(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r, x;
    r = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r = r ^ x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'h1b : 8'h00);
    end
    return r;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    logic [7:0] o;
    o = v;
    for (int i = 0; i < n; i++) o = {o[6:0], o[7]};
    return o;
  endfunction

  function automatic logic [10:0][127:0] expand(input logic [127:0] key);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    logic [10:0][127:0] ks;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = key[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = gm(rc, 8'h02);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) ks[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    return ks;
  endfunction

  function automatic logic [127:0] encrypt(input logic [127:0] pt, input logic [10:0][127:0] ks);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int i = 0; i < 16; i++) s[i] = pt[127-8*i -: 8] ^ ks[0][127-8*i -: 8];
    for (int rnd = 1; rnd <= 10; rnd++) begin
      for (int i = 0; i < 16; i++) s[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) t[c*4+r] = s[((c+r)%4)*4+r];
      for (int c = 0; c < 4; c++) begin
        if (rnd < 10) begin
          s[c*4+0] = gm(t[c*4],8'h02) ^ gm(t[c*4+1],8'h03) ^ t[c*4+2] ^ t[c*4+3];
          s[c*4+1] = t[c*4] ^ gm(t[c*4+1],8'h02) ^ gm(t[c*4+2],8'h03) ^ t[c*4+3];
          s[c*4+2] = t[c*4] ^ t[c*4+1] ^ gm(t[c*4+2],8'h02) ^ gm(t[c*4+3],8'h03);
          s[c*4+3] = gm(t[c*4],8'h03) ^ t[c*4+1] ^ t[c*4+2] ^ gm(t[c*4+3],8'h02);
        end else begin
          for (int r = 0; r < 4; r++) s[c*4+r] = t[c*4+r];
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ ks[rnd][127-8*i -: 8];
    end
    for (int i = 0; i < 16; i++) o[127-8*i -: 8] = s[i];
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [3:0] e_idx;
    e_idx = m_busy ? 4'((m_k - 1) / 4 + 1) : 4'd0;
    chk(in_ready === !m_busy, "R2/R3 in_ready", 128'(in_ready), 128'(!m_busy));
    chk(done === m_done, "R6 done", 128'(done), 128'(m_done));
    chk(rnd_idx === e_idx, "R4 rnd_idx", 128'(rnd_idx), 128'(e_idx));
    if (m_done) chk(out_block === m_held, "R7 ciphertext at done", out_block, m_held);
    else if (!m_busy) chk(out_block === m_held, "R8 held result", out_block, m_held);
  endtask

  task automatic cyc(input logic v, input logic [127:0] p, input logic [127:0] k);
    bit acc;
    compare();
    acc = v && !m_busy;
    in_valid = v;
    in_block = p;
    if (acc) begin
      sched = expand(k);
      m_exp = encrypt(p, sched);
    end
    @(posedge clk);
    m_done = 1'b0;
    if (acc) begin
      m_busy = 1'b1;
      m_k = 1;
    end else if (m_busy) begin
      m_k++;
      if (m_k == 41) begin
        m_busy = 1'b0;
        m_done = 1'b1;
        m_held = m_exp;
      end
    end
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] kat_k, kat_p, p, k;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv;
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (gm(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      sb[x] = inv ^ rl(inv,1) ^ rl(inv,2) ^ rl(inv,3) ^ rl(inv,4) ^ 8'h63;
    end
    kat_k = 128'h000102030405060708090a0b0c0d0e0f;
    kat_p = 128'h00112233445566778899aabbccddeeff;

    repeat (3) @(negedge clk);
    // R1: values during reset
    chk(in_ready === 1'b1 && done === 1'b0 && rnd_idx === 4'd0 && out_block === '0,
        "R1 reset state", {in_ready, done, rnd_idx, out_block[121:0]}, {1'b1, 1'b0, 4'd0, 122'd0});
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1 && done === 1'b0 && rnd_idx === 4'd0 && out_block === '0,
        "R1 after reset", {in_ready, done, rnd_idx, out_block[121:0]}, {1'b1, 1'b0, 4'd0, 122'd0});
    repeat (2) cyc(1'b0, '0, '0);

    // R7 R5: known-answer block, with offers while busy (R3)
    cyc(1'b1, kat_p, kat_k);
    repeat (12) cyc(1'b0, '0, '0);
    repeat (3) cyc(1'b1, ~kat_p, ~kat_k);
    while (m_busy) cyc(1'b0, '0, '0);
    chk(out_block === 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R5/R7 known answer",
        out_block, 128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    chk(out_block === m_held, "R3 ignored offer left result intact", out_block, m_held);
    repeat (3) cyc(1'b0, '0, '0);

    // R8 R2: back-to-back, next block offered all through the previous one
    for (int b = 0; b < 5; b++) begin
      if (b == 0) begin p = '0; k = '0; end
      else begin
        p = {$urandom, $urandom, $urandom, $urandom};
        k = {$urandom, $urandom, $urandom, $urandom};
      end
      while (m_busy) cyc(1'b1, p, k);
      cyc(1'b1, p, k);
    end
    while (m_busy) cyc(1'b0, '0, '0);
    repeat (5) cyc(1'b0, '0, '0);
    compare();
    summary();
    $finish;
  end
endmodule